// File: doc/BRIEF.md
# Carry-Select Adder

This block adds two N-bit operands and a carry input and gives the N-bit sum and a carry output. The operand width is cut into M equal blocks of P ripple cells. The lowest block is an ordinary ripple adder fed by the external carry input. Every higher block runs two ripple chains side by side over its own operand bits. One chain assumes an incoming carry of 0 and the other assumes 1. When the real carry from the block below settles, a single selector passes on the matching sum slice and block carry.

The carry that crosses a block therefore goes through one selector level rather than P cells. The block is purely combinational and has no clock, reset or handshake. The adder's delay grows roughly as P·k1 + (M−1)·k2. Here k1 is the delay of one cell and k2 is the delay of one selector. The best block count lies near the square root of k1·N/k2, and the parameters N and P are chosen from that guideline. The default build is 6 bits in two blocks of 3.

Top module: `csel_adder`

## Requirements
- R1: For every input, {carry_out, sum} equals op_a + op_b + carry_in taken as an (N+1)-bit unsigned value.
- R2: N must be a whole multiple of P, and the adder is then built from M = N/P blocks. A 16-bit build with P = 4 (four blocks) behaves as in R1.
- R3: The lowest P sum bits depend only on the lowest P operand bits and carry_in: sum[P-1:0] equals the low P bits of op_a[P-1:0] + op_b[P-1:0] + carry_in.
- R4: The carry entering upper block k (bit position k·P) equals the carry produced by adding bits below k·P together with carry_in, including carries that ripple across a block boundary.
- R5: In every upper block, the result precomputed with incoming carry 1 equals the result precomputed with incoming carry 0 plus one, taken over the P sum bits and the block carry.
- R6: In every upper block, the sum slice and the block carry both come from the precomputed pair chosen by that block's incoming carry.
- R7: When op_a XOR op_b is all ones, carry_out equals carry_in and sum equals the inverse of carry_in on every bit.
- R8: When both operands have their top bit set, carry_out is 1 whatever the other bits and carry_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | N | First operand |
| op_b | input | N | Second operand |
| carry_in | input | 1 | Carry into the lowest bit |
| sum | output | N | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The bench builds two copies of the block. The first uses the default 6-bit, two-block shape, small enough that all 8192 combinations of both operands and the carry input are applied. This covers every boundary carry and every selector choice of the single upper block. The second is 16 bits in four blocks of 4. It is driven with random vectors and with full-propagate and top-bit-generate patterns, so a carry that must pass through several selectors in a row is exercised.

// File: rtl/csel_pkg.sv
package csel_pkg;
  function automatic int blk_count(input int width, input int cells);
    return width / cells;
  endfunction
endpackage

// File: rtl/csel_cell.sv
module csel_cell (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  logic differ;
  always_comb begin
    differ = a ^ b;
    // equal operands: sum follows carry, carry takes operand value
    s  = differ ? ~ci : ci;
    co = differ ? ci : a;
  end
endmodule

// File: rtl/csel_ripple.sv
module csel_ripple #(
  parameter int W = 3
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] chain;
  assign chain[0] = ci;
  for (genvar i = 0; i < W; i++) begin : g_cell
    csel_cell u_cell (
      .a (a[i]),
      .b (b[i]),
      .ci(chain[i]),
      .s (s[i]),
      .co(chain[i+1])
    );
  end
  assign co = chain[W];
endmodule

// File: rtl/csel_block.sv
module csel_block #(
  parameter int P = 3
) (
  input  logic [P-1:0] a,
  input  logic [P-1:0] b,
  input  logic         sel,
  output logic [P-1:0] s,
  output logic         co,
  output logic [P-1:0] s_if0,
  output logic         c_if0,
  output logic [P-1:0] s_if1,
  output logic         c_if1
);
  csel_ripple #(.W(P)) u_zero (
    .a(a), .b(b), .ci(1'b0), .s(s_if0), .co(c_if0)
  );
  csel_ripple #(.W(P)) u_one (
    .a(a), .b(b), .ci(1'b1), .s(s_if1), .co(c_if1)
  );
  always_comb begin
    if (sel) begin
      s  = s_if1;
      co = c_if1;
    end else begin
      s  = s_if0;
      co = c_if0;
    end
  end
endmodule

// File: rtl/csel_adder.sv
module csel_adder #(
  parameter int N = 6,
  parameter int P = 3
) (
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  input  logic         carry_in,
  output logic [N-1:0] sum,
  output logic         carry_out
);
  localparam int M = csel_pkg::blk_count(N, P);

  if ((N % P) != 0 || P < 1) begin : g_bad_cfg
    initial $fatal(1, "csel_adder: width %0d is not a multiple of block size %0d", N, P);
  end

  logic [M:0]          blk_cy;
  logic [M-1:0][P-1:0] pre0_s;
  logic [M-1:0][P-1:0] pre1_s;
  logic [M-1:0]        pre0_c;
  logic [M-1:0]        pre1_c;

  assign blk_cy[0] = carry_in;

  for (genvar k = 0; k < M; k++) begin : g_blk
    if (k == 0) begin : g_base
      csel_ripple #(.W(P)) u_base (
        .a (op_a[P-1:0]),
        .b (op_b[P-1:0]),
        .ci(blk_cy[0]),
        .s (sum[P-1:0]),
        .co(blk_cy[1])
      );
      assign pre0_s[0] = sum[P-1:0];
      assign pre1_s[0] = sum[P-1:0];
      assign pre0_c[0] = blk_cy[1];
      assign pre1_c[0] = blk_cy[1];
    end else begin : g_upper
      csel_block #(.P(P)) u_sel (
        .a    (op_a[k*P +: P]),
        .b    (op_b[k*P +: P]),
        .sel  (blk_cy[k]),
        .s    (sum[k*P +: P]),
        .co   (blk_cy[k+1]),
        .s_if0(pre0_s[k]),
        .c_if0(pre0_c[k]),
        .s_if1(pre1_s[k]),
        .c_if1(pre1_c[k])
      );
    end
  end

  assign carry_out = blk_cy[M];
endmodule

// File: rtl/csel_adder_chk.sv
module csel_adder_chk #(
  parameter int N = 6,
  parameter int P = 3,
  parameter int M = N / P
) (
  input logic [N-1:0]          op_a,
  input logic [N-1:0]          op_b,
  input logic                  carry_in,
  input logic [N-1:0]          sum,
  input logic                  carry_out,
  input logic [M:0]            blk_cy,
  input logic [M-1:0][P-1:0]   pre0_s,
  input logic [M-1:0][P-1:0]   pre1_s,
  input logic [M-1:0]          pre0_c,
  input logic [M-1:0]          pre1_c
);
  logic [N:0] full_ref;
  logic [P:0] low_ref;
  logic       known;

  always_comb begin
    known    = !$isunknown({op_a, op_b, carry_in});
    full_ref = {1'b0, op_a} + {1'b0, op_b} + {{N{1'b0}}, carry_in};
    low_ref  = {1'b0, op_a[P-1:0]} + {1'b0, op_b[P-1:0]} + {{P{1'b0}}, carry_in};
    if (known) begin
      assert_total_R1: assert final ({carry_out, sum} == full_ref);
      assert_low_blk_R3: assert final (sum[P-1:0] == low_ref[P-1:0]);
    end
  end

  for (genvar k = 1; k < M; k++) begin : g_chk
    logic [N:0] part_mask;
    logic [N:0] part_sum;
    always_comb begin
      part_mask = ~({(N+1){1'b1}} << (k*P));
      part_sum  = ({1'b0, op_a} & part_mask) + ({1'b0, op_b} & part_mask)
                  + {{N{1'b0}}, carry_in};
      if (known) begin
        assert_boundary_R4: assert final (blk_cy[k] == part_sum[k*P]);
        assert_pair_R5: assert final ({pre1_c[k], pre1_s[k]} == {pre0_c[k], pre0_s[k]} + 1'b1);
        assert_pick_R6: assert final (blk_cy[k]
                                      ? ({blk_cy[k+1], sum[k*P +: P]} == {pre1_c[k], pre1_s[k]})
                                      : ({blk_cy[k+1], sum[k*P +: P]} == {pre0_c[k], pre0_s[k]}));
      end
    end
  end
endmodule

bind csel_adder csel_adder_chk #(.N(N), .P(P)) u_chk (
  .op_a     (op_a),
  .op_b     (op_b),
  .carry_in (carry_in),
  .sum      (sum),
  .carry_out(carry_out),
  .blk_cy   (blk_cy),
  .pre0_s   (pre0_s),
  .pre1_s   (pre1_s),
  .pre0_c   (pre0_c),
  .pre1_c   (pre1_c)
);

// File: tb/sim_csel_adder.sv
`timescale 1ns/1ps
module sim_csel_adder;
  localparam int NS = 6;
  localparam int PS = 3;
  localparam int NW = 16;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [NS-1:0] a0, b0, s0;
  logic          c0, co0;
  logic [NW-1:0] a1, b1, s1;
  logic          c1, co1;

  csel_adder #(.N(NS), .P(PS)) u0 (
    .op_a(a0), .op_b(b0), .carry_in(c0), .sum(s0), .carry_out(co0)
  );
  csel_adder #(.N(NW), .P(PW)) u1 (
    .op_a(a1), .op_b(b1), .carry_in(c1), .sum(s1), .carry_out(co1)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [NS:0] q0_exp[$];
  string       q0_tag[$];
  logic [NW:0] q1_exp[$];
  string       q1_tag[$];

  task automatic drive_small(input logic [NS-1:0] a, input logic [NS-1:0] b,
                             input logic ci, input string tag);
    @(negedge clk);
    a0 = a; b0 = b; c0 = ci;
    q0_exp.push_back({1'b0, a} + {1'b0, b} + {{NS{1'b0}}, ci});
    q0_tag.push_back(tag);
  endtask

  task automatic drive_wide(input logic [NW-1:0] a, input logic [NW-1:0] b,
                            input logic ci, input string tag);
    @(negedge clk);
    a1 = a; b1 = b; c1 = ci;
    q1_exp.push_back({1'b0, a} + {1'b0, b} + {{NW{1'b0}}, ci});
    q1_tag.push_back(tag);
  endtask

  // monitor: compare what each adder shows against the oldest expectation
  always @(posedge clk) begin
    if (q0_exp.size() > 0) begin
      logic [NS:0] e;
      string t;
      e = q0_exp.pop_front();
      t = q0_tag.pop_front();
      checks++;
      if ({co0, s0} !== e) begin
        fails++;
        $display("FAIL %s: 6-bit got %h expected %h (a=%h b=%h cin=%b)", t, {co0, s0}, e, a0, b0, c0);
      end
      if (t == "R3") begin
        logic [PS:0] lo;
        lo = {1'b0, a0[PS-1:0]} + {1'b0, b0[PS-1:0]} + {{PS{1'b0}}, c0};
        checks++;
        if (s0[PS-1:0] !== lo[PS-1:0]) begin
          fails++;
          $display("FAIL R3: low slice got %h expected %h", s0[PS-1:0], lo[PS-1:0]);
        end
      end
    end
    if (q1_exp.size() > 0) begin
      logic [NW:0] e;
      string t;
      e = q1_exp.pop_front();
      t = q1_tag.pop_front();
      checks++;
      if ({co1, s1} !== e) begin
        fails++;
        $display("FAIL %s: 16-bit got %h expected %h (a=%h b=%h cin=%b)", t, {co1, s1}, e, a1, b1, c1);
      end
      if (t == "R7") begin
        checks++;
        if (co1 !== c1 || s1 !== {NW{~c1}}) begin
          fails++;
          $display("FAIL R7: propagate got co=%b s=%h expected co=%b s=%h", co1, s1, c1, {NW{~c1}});
        end
      end
      if (t == "R8") begin
        checks++;
        if (co1 !== 1'b1) begin
          fails++;
          $display("FAIL R8: generate got co=%b expected 1", co1);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    a0 = '0; b0 = '0; c0 = 1'b0;
    a1 = '0; b1 = '0; c1 = 1'b0;
    q0_exp.push_back('0); q0_tag.push_back("R1 idle");
    q1_exp.push_back('0); q1_tag.push_back("R2 idle");
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // R3 and R4: carries across the 3-bit boundary
    drive_small(6'b000111, 6'b000001, 1'b0, "R4");
    drive_small(6'b000011, 6'b000100, 1'b1, "R4");
    drive_small(6'b101010, 6'b010101, 1'b1, "R3");
    drive_small(6'b111000, 6'b000111, 1'b0, "R3");
    // R1, R5, R6: every combination at 6 bits
    for (int v = 0; v < (1 << (2*NS + 1)); v++) begin
      drive_small(v[NS-1:0], v[2*NS-1:NS], v[2*NS], "R1");
    end

    // R7: full propagate through four blocks
    drive_wide(16'hAAAA, 16'h5555, 1'b0, "R7");
    drive_wide(16'hAAAA, 16'h5555, 1'b1, "R7");
    drive_wide(16'hFFFF, 16'h0000, 1'b1, "R7");
    drive_wide(16'h0F0F, 16'hF0F0, 1'b0, "R7");
    // R8: top bits generate
    drive_wide(16'h8000, 16'h8000, 1'b0, "R8");
    drive_wide(16'hFFFF, 16'hFFFF, 1'b1, "R8");
    drive_wide(16'hC123, 16'h9ABC, 1'b0, "R8");
    // R4 at 16 bits: carry born in block 0 crossing three selectors
    drive_wide(16'h0FFF, 16'h0001, 1'b0, "R4");
    drive_wide(16'hFFF0, 16'h000F, 1'b1, "R4");
    // R2: random vectors on the four-block build
    for (int r = 0; r < 2000; r++) begin
      drive_wide(16'($urandom), 16'($urandom), 1'($urandom), "R2");
    end

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule